// File: doc/BRIEF.md
# Cache Permission Epoch Tracker

This block runs beside a cache controller and keeps a record of every block whose permission the cache currently holds. An epoch starts when the coherence controller grants a permission on a block and ends when that permission is taken away. For each open epoch the tracker stores the block address, whether the permission is read-write or read-only, the logical time the epoch began, and a 32-bit digest of the block data at that moment. The full block data is not kept.

Loads and stores that are replayed for checking are compared against the open epochs. A store needs an open read-write epoch. A load is accepted under either kind of epoch. Any other access raises a one-cycle error pulse. The replay path is never stalled. When an epoch closes, the tracker builds a summary record and passes it toward the memory-side verifier over a valid/ready stream. The record holds the kind of epoch, the begin time, the begin digest, the end time and the end digest. If a grant arrives for a block that is already open, the old epoch is closed and summarised first, and a new epoch then opens in the same slot. This is how an upgrade from read-only to read-write is handled.

Grant and revoke events enter on a valid/ready stream. The tracker holds at most one pending summary record. While that record waits for the consumer, `evt_ready` is low and no event of either kind is taken. The event producer must keep `evt_valid` and its payload steady until the event is accepted. The summary stream follows the same rule: once `inf_valid` is high, the record stays unchanged until a cycle in which `inf_ready` is high.

Top module: `epoch_tracker`

## Requirements
- R1: After reset no epoch is open, `inf_valid` is 0, `evt_ready` is 1, and both error outputs are 0.
- R2: An accepted grant (`evt_kind`=0) for an address with no open epoch, made while a slot is free, opens an epoch. The kind of epoch comes from `evt_rw`, where 1 means read-write and 0 means read-only. No summary record is produced.
- R3: A replayed access (`acc_valid`=1) to an address with no open epoch sets `err_access` to 1 in the following cycle.
- R4: A load (`acc_store`=0) to an open epoch of either kind gives `err_access`=0 in the following cycle. A store (`acc_store`=1) gives 0 under a read-write epoch and 1 under a read-only epoch.
- R5: An accepted revoke (`evt_kind`=1) for an open address closes that epoch. In the following cycle it presents a record with `inf_valid`=1 and these fields:
  - `inf_addr`
  - `inf_rw` (the kind of the closed epoch)
  - `inf_begin_time` and `inf_begin_hash` (taken from the grant)
  - `inf_end_time` and `inf_end_hash` (taken from the revoke)
- R6: Each digest is the standard CRC-32 of the 128-bit data, taken as 16 bytes with byte 0 = bits [7:0] first. Each byte is processed least significant bit first, using the reflected polynomial 0xEDB88320, an initial value of 0xFFFFFFFF and a final inversion.
- R7: A revoke for an address with no open epoch is accepted and otherwise has no effect. No record is produced, `evt_ready` stays 1, and no open epoch changes.
- R8: A grant for an already open address first presents the record of the old epoch. Its end time and end digest come from the grant. In the same step the slot takes the grant's kind, time and digest.
- R9: A grant for a new address when all ENTRIES slots are open sets `err_overflow` to 1 in the following cycle and opens nothing. A slot freed by a revoke can be reused by a later grant.
- R10: While `inf_valid` is 1 and `inf_ready` is 0, the record stays unchanged and `evt_ready` is 0. An event that is held waiting is not acted on.
- R11: An access and an event in the same cycle: the access is judged against the epochs as they stood before that event.
- R12: Each error output is high only in the cycle after its cause. An event that causes no error leaves the error output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event accepted this cycle when high together with evt_valid |
| evt_kind | input | 1 | 0 grant, 1 revoke |
| evt_rw | input | 1 | Grant kind: 1 read-write, 0 read-only |
| evt_addr | input | ADDR_W | Block address |
| evt_time | input | TIME_W | Logical timestamp |
| evt_data | input | DATA_W | Block data at the event |
| acc_valid | input | 1 | Replayed access present |
| acc_store | input | 1 | 1 store, 0 load |
| acc_addr | input | ADDR_W | Access block address |
| err_access | output | 1 | Access violated its epoch (one cycle later) |
| err_overflow | output | 1 | Grant found no free slot (one cycle later) |
| inf_valid | output | 1 | Summary record present |
| inf_ready | input | 1 | Consumer takes the record |
| inf_addr | output | ADDR_W | Address of the closed epoch |
| inf_rw | output | 1 | Kind of the closed epoch |
| inf_begin_time | output | TIME_W | Begin time |
| inf_begin_hash | output | 32 | Begin digest |
| inf_end_time | output | TIME_W | End time |
| inf_end_hash | output | 32 | End digest |

## Verification
An access check and an event that changes the table can fall in the same cycle. The bench provokes this in two ways. First, it drives a store to an open read-write block in the same cycle as the revoke that closes that block. Second, it drives a load to a new block in the same cycle as the grant that opens it. Both are judged by R11: the store must pass and the load must fail, because each access sees the table from before the event. A follow-up access in the next cycle then confirms the new state. A held summary record in the same cycle as a waiting revoke is also driven. The bench checks that the revoke is taken only after the record drains.

// File: rtl/epoch_pkg.sv
package epoch_pkg;
  localparam int HASH_W = 32;
  localparam logic [HASH_W-1:0] CRC_POLY = 32'hEDB88320;
  typedef enum logic { EV_GRANT = 1'b0, EV_REVOKE = 1'b1 } ev_kind_e;
endpackage

// File: rtl/epoch_crc32.sv
module epoch_crc32 #(
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0]               din,
  output logic [epoch_pkg::HASH_W-1:0]    crc
);
  import epoch_pkg::*;
  logic [HASH_W-1:0] acc;
  logic              fb;

  // bitwise reflected CRC, bit 0 first, unrolled into one combinational cone
  always_comb begin
    acc = '1;
    fb  = 1'b0;
    for (int b = 0; b < DATA_W; b++) begin
      fb  = acc[0] ^ din[b];
      acc = acc >> 1;
      if (fb) acc = acc ^ CRC_POLY;
    end
    crc = ~acc;
  end
endmodule

// File: rtl/epoch_table.sv
module epoch_table #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int TIME_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             evt_addr,
  input  logic [ADDR_W-1:0]             acc_addr,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic                          wr_rw,
  input  logic [TIME_W-1:0]             wr_time,
  input  logic [epoch_pkg::HASH_W-1:0]  wr_hash,
  input  logic                          clr_en,
  input  logic [IDX_W-1:0]              clr_idx,
  output logic                          evt_hit,
  output logic [IDX_W-1:0]              evt_idx,
  output logic                          evt_rw,
  output logic [TIME_W-1:0]             evt_time_q,
  output logic [epoch_pkg::HASH_W-1:0]  evt_hash_q,
  output logic                          acc_hit,
  output logic                          acc_rw,
  output logic                          free_any,
  output logic [IDX_W-1:0]              free_idx
);
  import epoch_pkg::*;
  logic [ENTRIES-1:0]              slot_vld;
  logic [ENTRIES-1:0]              slot_rw;
  logic [ADDR_W-1:0]               slot_addr [ENTRIES];
  logic [TIME_W-1:0]               slot_time [ENTRIES];
  logic [HASH_W-1:0]               slot_hash [ENTRIES];
  logic [ENTRIES-1:0]              evt_match, acc_match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign evt_match[g] = slot_vld[g] && (slot_addr[g] == evt_addr);
    assign acc_match[g] = slot_vld[g] && (slot_addr[g] == acc_addr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vld[g]  <= 1'b0;
        slot_rw[g]   <= 1'b0;
        slot_addr[g] <= '0;
        slot_time[g] <= '0;
        slot_hash[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        slot_vld[g]  <= 1'b1;
        slot_rw[g]   <= wr_rw;
        slot_addr[g] <= evt_addr;
        slot_time[g] <= wr_time;
        slot_hash[g] <= wr_hash;
      end else if (clr_en && clr_idx == IDX_W'(g)) begin
        slot_vld[g]  <= 1'b0;
      end
    end
  end

  always_comb begin
    evt_hit    = |evt_match;
    evt_idx    = '0;
    evt_rw     = 1'b0;
    evt_time_q = '0;
    evt_hash_q = '0;
    acc_hit    = |acc_match;
    acc_rw     = 1'b0;
    free_any   = ~&slot_vld;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (evt_match[i]) begin
        evt_idx    = IDX_W'(i);
        evt_rw     = slot_rw[i];
        evt_time_q = slot_time[i];
        evt_hash_q = slot_hash[i];
      end
      if (acc_match[i]) acc_rw = slot_rw[i];
      if (!slot_vld[i]) free_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/epoch_tracker.sv
module epoch_tracker #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int TIME_W  = 32,
  parameter int DATA_W  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic              evt_kind,
  input  logic              evt_rw,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [TIME_W-1:0] evt_time,
  input  logic [DATA_W-1:0] evt_data,
  input  logic              acc_valid,
  input  logic              acc_store,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              err_access,
  output logic              err_overflow,
  output logic              inf_valid,
  input  logic              inf_ready,
  output logic [ADDR_W-1:0] inf_addr,
  output logic              inf_rw,
  output logic [TIME_W-1:0] inf_begin_time,
  output logic [31:0]       inf_begin_hash,
  output logic [TIME_W-1:0] inf_end_time,
  output logic [31:0]       inf_end_hash
);
  import epoch_pkg::*;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [HASH_W-1:0] evt_hash;
  logic              accept, is_grant, emit;
  logic              t_evt_hit, t_evt_rw, t_acc_hit, t_acc_rw, t_free_any;
  logic [IDX_W-1:0]  t_evt_idx, t_free_idx;
  logic [TIME_W-1:0] t_time;
  logic [HASH_W-1:0] t_hash;
  logic              wr_en, clr_en;
  logic [IDX_W-1:0]  wr_idx;

  epoch_crc32 #(.DATA_W(DATA_W)) u_crc (.din(evt_data), .crc(evt_hash));

  assign evt_ready = !inf_valid;
  assign accept    = evt_valid && evt_ready;
  assign is_grant  = (ev_kind_e'(evt_kind) == EV_GRANT);
  assign emit      = accept && t_evt_hit;
  assign wr_en     = accept && is_grant && (t_evt_hit || t_free_any);
  assign wr_idx    = t_evt_hit ? t_evt_idx : t_free_idx;
  assign clr_en    = accept && !is_grant && t_evt_hit;

  epoch_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TIME_W(TIME_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .evt_addr(evt_addr), .acc_addr(acc_addr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_rw(evt_rw),
    .wr_time(evt_time), .wr_hash(evt_hash),
    .clr_en(clr_en), .clr_idx(t_evt_idx),
    .evt_hit(t_evt_hit), .evt_idx(t_evt_idx), .evt_rw(t_evt_rw),
    .evt_time_q(t_time), .evt_hash_q(t_hash),
    .acc_hit(t_acc_hit), .acc_rw(t_acc_rw),
    .free_any(t_free_any), .free_idx(t_free_idx)
  );

  // summary record register: one slot, drained by inf_ready
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inf_valid      <= 1'b0;
      inf_addr       <= '0;
      inf_rw         <= 1'b0;
      inf_begin_time <= '0;
      inf_begin_hash <= '0;
      inf_end_time   <= '0;
      inf_end_hash   <= '0;
    end else if (emit) begin
      inf_valid      <= 1'b1;
      inf_addr       <= evt_addr;
      inf_rw         <= t_evt_rw;
      inf_begin_time <= t_time;
      inf_begin_hash <= t_hash;
      inf_end_time   <= evt_time;
      inf_end_hash   <= evt_hash;
    end else if (inf_valid && inf_ready) begin
      inf_valid      <= 1'b0;
    end
  end

  // error pulses, judged against pre-event table state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_access   <= 1'b0;
      err_overflow <= 1'b0;
    end else begin
      err_access   <= acc_valid && (!t_acc_hit || (acc_store && !t_acc_rw));
      err_overflow <= accept && is_grant && !t_evt_hit && !t_free_any;
    end
  end
endmodule

// File: rtl/epoch_tracker_chk.sv
module epoch_tracker_chk #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int TIME_W  = 32,
  parameter int DATA_W  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic              evt_kind,
  input logic              evt_rw,
  input logic [ADDR_W-1:0] evt_addr,
  input logic [TIME_W-1:0] evt_time,
  input logic [DATA_W-1:0] evt_data,
  input logic              acc_valid,
  input logic              acc_store,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              err_access,
  input logic              err_overflow,
  input logic              inf_valid,
  input logic              inf_ready,
  input logic [ADDR_W-1:0] inf_addr,
  input logic              inf_rw,
  input logic [TIME_W-1:0] inf_begin_time,
  input logic [31:0]       inf_begin_hash,
  input logic [TIME_W-1:0] inf_end_time,
  input logic [31:0]       inf_end_hash
);
  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    inf_valid |-> !evt_ready);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inf_valid && !inf_ready) |=> (inf_valid && $stable(inf_addr) && $stable(inf_rw)
      && $stable(inf_begin_time) && $stable(inf_begin_hash)
      && $stable(inf_end_time) && $stable(inf_end_hash)));

  a_r5_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inf_valid) |-> $past(evt_valid && evt_ready));

  a_r5_end_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inf_valid) |-> (inf_end_time == $past(evt_time) && inf_addr == $past(evt_addr)));

  a_r9_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |-> $past(evt_valid && evt_ready && !evt_kind));

  a_r3_access_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_access |-> $past(acc_valid));

  a_r12_overflow_no_record: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |-> !$rose(inf_valid));
endmodule

bind epoch_tracker epoch_tracker_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TIME_W(TIME_W), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/epoch_tracker_tb_top.sv
`timescale 1ns/1ps
module epoch_tracker_tb_top;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         evt_valid = 1'b0, evt_kind = 1'b0, evt_rw = 1'b0;
  logic [31:0]  evt_addr = '0, evt_time = '0;
  logic [127:0] evt_data = '0;
  logic         acc_valid = 1'b0, acc_store = 1'b0;
  logic [31:0]  acc_addr = '0;
  logic         inf_ready = 1'b1;
  logic         evt_ready, err_access, err_overflow, inf_valid, inf_rw;
  logic [31:0]  inf_addr, inf_begin_time, inf_begin_hash, inf_end_time, inf_end_hash;

  int total = 0, fails = 0;

  bit           open_q [N];
  bit           rw_q   [N];
  logic [31:0]  bt_q   [N];
  logic [127:0] bd_q   [N];

  always #2.5 clk = ~clk;

  epoch_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_kind(evt_kind), .evt_rw(evt_rw), .evt_addr(evt_addr), .evt_time(evt_time),
    .evt_data(evt_data), .acc_valid(acc_valid), .acc_store(acc_store), .acc_addr(acc_addr),
    .err_access(err_access), .err_overflow(err_overflow), .inf_valid(inf_valid),
    .inf_ready(inf_ready), .inf_addr(inf_addr), .inf_rw(inf_rw),
    .inf_begin_time(inf_begin_time), .inf_begin_hash(inf_begin_hash),
    .inf_end_time(inf_end_time), .inf_end_hash(inf_end_hash)
  );

  // bytewise CRC-32, byte 0 = bits [7:0]
  function automatic logic [31:0] ref_crc(input logic [127:0] d);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 16; k++) begin
      c = c ^ {24'h0, d[k*8 +: 8]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [31:0] addr_of(input int i);
    return 32'h0000_1000 + 32'(i) * 32'h40;
  endfunction

  function automatic logic [127:0] data_of(input int i, input int salt);
    return {32'(i * 7 + salt), 32'hA5A5_0000 ^ 32'(i), 32'(salt) * 32'h0101_0101, ~32'(i)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one event (optionally with an access in the same cycle); returns 1ns after the accepting edge
  task automatic send(input bit kind, input bit rw, input logic [31:0] a, input logic [31:0] t,
                      input logic [127:0] d, input bit with_acc, input bit st, input logic [31:0] aa);
    @(negedge clk);
    while (!evt_ready) @(negedge clk);
    evt_valid = 1'b1; evt_kind = kind; evt_rw = rw; evt_addr = a; evt_time = t; evt_data = d;
    acc_valid = with_acc; acc_store = st; acc_addr = aa;
    @(posedge clk); #1;
    evt_valid = 1'b0; acc_valid = 1'b0;
  endtask

  task automatic access(input bit st, input logic [31:0] a, input bit exp_err, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_store = st; acc_addr = a;
    @(posedge clk); #1;
    acc_valid = 1'b0;
    check(err_access == exp_err, tag, 64'(err_access), 64'(exp_err));
  endtask

  task automatic expect_record(input logic [31:0] a, input bit rw, input logic [31:0] bt,
                               input logic [127:0] bd, input logic [31:0] et,
                               input logic [127:0] ed, input string tag);
    check(inf_valid == 1'b1, {tag, " valid"}, 64'(inf_valid), 64'd1);
    check(inf_addr == a && inf_rw == rw, {tag, " addr/kind"}, {inf_addr, 31'd0, inf_rw}, {a, 31'd0, rw});
    check(inf_begin_time == bt && inf_begin_hash == ref_crc(bd), {tag, " begin"},
          {inf_begin_time, inf_begin_hash}, {bt, ref_crc(bd)});
    check(inf_end_time == et && inf_end_hash == ref_crc(ed), {tag, " end"},
          {inf_end_time, inf_end_hash}, {et, ref_crc(ed)});
  endtask

  initial begin
    #1000000;
    fails++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check(evt_ready && !inf_valid && !err_access && !err_overflow, "R1 reset outputs",
          {evt_ready, inf_valid, err_access, err_overflow}, 64'h8);
    access(1'b0, addr_of(0), 1'b1, "R1 R3 empty table load");

    // R2 fill every slot, alternating kinds
    for (int i = 0; i < N; i++) begin
      open_q[i] = 1; rw_q[i] = i[0]; bt_q[i] = 32'(100 + i); bd_q[i] = data_of(i, 3);
      send(1'b0, rw_q[i], addr_of(i), bt_q[i], bd_q[i], 1'b0, 1'b0, '0);
      check(!inf_valid && !err_overflow, "R2 new grant no record", {inf_valid, err_overflow}, 64'd0);
    end
    // R4 load/store sweep over all slots
    for (int i = 0; i < N; i++) begin
      access(1'b0, addr_of(i), 1'b0, "R4 load in open epoch");
      access(1'b1, addr_of(i), !rw_q[i], "R4 store vs epoch kind");
    end
    access(1'b1, 32'h0000_7777, 1'b1, "R3 store no epoch");

    // R9 overflow then pulse ends (R12)
    send(1'b0, 1'b1, 32'h0000_9000, 32'd400, data_of(99, 1), 1'b0, 1'b0, '0);
    check(err_overflow == 1'b1, "R9 overflow pulse", 64'(err_overflow), 64'd1);
    @(posedge clk); #1;
    check(err_overflow == 1'b0, "R12 overflow one cycle", 64'(err_overflow), 64'd0);
    access(1'b0, 32'h0000_9000, 1'b1, "R9 dropped grant not open");

    // R7 revoke of unknown block
    send(1'b1, 1'b0, 32'h0000_9000, 32'd410, data_of(98, 1), 1'b0, 1'b0, '0);
    check(!inf_valid && evt_ready, "R7 revoke miss no record", {inf_valid, evt_ready}, 64'd1);
    access(1'b0, addr_of(5), 1'b0, "R7 other epoch untouched");

    // R8 upgrade of slot 0 (read-only) to read-write
    send(1'b0, 1'b1, addr_of(0), 32'd500, data_of(0, 9), 1'b0, 1'b0, '0);
    expect_record(addr_of(0), 1'b0, bt_q[0], bd_q[0], 32'd500, data_of(0, 9), "R8 upgrade record");
    rw_q[0] = 1; bt_q[0] = 32'd500; bd_q[0] = data_of(0, 9);
    access(1'b1, addr_of(0), 1'b0, "R8 store after upgrade");

    // R11 revoke and store to same block in one cycle
    send(1'b1, 1'b0, addr_of(1), 32'd520, data_of(1, 4), 1'b1, 1'b1, addr_of(1));
    check(err_access == 1'b0, "R11 store sees pre-revoke table", 64'(err_access), 64'd0);
    expect_record(addr_of(1), 1'b1, bt_q[1], bd_q[1], 32'd520, data_of(1, 4), "R5 revoke record");
    open_q[1] = 0;
    access(1'b1, addr_of(1), 1'b1, "R5 closed epoch rejects store");

    // R9 freed slot reused; R11 grant and load same cycle
    send(1'b0, 1'b0, 32'h0000_9000, 32'd530, data_of(50, 2), 1'b1, 1'b0, 32'h0000_9000);
    check(err_access == 1'b1 && err_overflow == 1'b0, "R11 load sees pre-grant table",
          {err_access, err_overflow}, 64'h2);
    access(1'b0, 32'h0000_9000, 1'b0, "R9 reused slot open");

    // R10 held record back-pressures a waiting revoke
    inf_ready = 1'b0;
    send(1'b1, 1'b0, addr_of(2), 32'd600, data_of(2, 5), 1'b0, 1'b0, '0);
    expect_record(addr_of(2), rw_q[2], bt_q[2], bd_q[2], 32'd600, data_of(2, 5), "R10 first record");
    open_q[2] = 0;
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = 1'b1; evt_addr = addr_of(3); evt_time = 32'd610; evt_data = data_of(3, 6);
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      check(inf_valid && !evt_ready && inf_addr == addr_of(2) && inf_end_time == 32'd600,
            "R10 record held", {inf_addr, inf_end_time}, {addr_of(2), 32'd600});
    end
    @(negedge clk);
    acc_valid = 1'b1; acc_store = 1'b0; acc_addr = addr_of(3);
    inf_ready = 1'b1;
    @(posedge clk); #1;
    acc_valid = 1'b0;
    check(err_access == 1'b0, "R10 waiting revoke not applied", 64'(err_access), 64'd0);
    check(!inf_valid && evt_ready, "R10 record drained", {inf_valid, evt_ready}, 64'd1);
    @(posedge clk); #1;
    evt_valid = 1'b0;
    expect_record(addr_of(3), rw_q[3], bt_q[3], bd_q[3], 32'd610, data_of(3, 6), "R10 revoke after drain");
    open_q[3] = 0;

    // R5 R6 close all remaining epochs
    for (int i = 0; i < N; i++) begin
      if (open_q[i]) begin
        send(1'b1, 1'b0, addr_of(i), 32'(700 + i), data_of(i, 11), 1'b0, 1'b0, '0);
        expect_record(addr_of(i), rw_q[i], bt_q[i], bd_q[i], 32'(700 + i), data_of(i, 11), "R6 closing sweep");
        open_q[i] = 0;
      end
    end
    for (int i = 0; i < N; i++) access(1'b0, addr_of(i), 1'b1, "R5 all closed");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule